// File: doc/BRIEF.md
# USB OUT Transaction Handshake Responder

This block sits behind the serial interface engine of a USB device and decides what happens to each OUT transaction. For every OUT token it checks the device address, the endpoint number and the endpoint's enable bit. It then either stores the following data packet into the endpoint FIFO, discards it, or ignores the transaction entirely. It also picks the handshake that goes back to the host.

For each endpoint the block keeps a buffer-full flag and a pending-interrupt bit. The interrupt bits drive a single interrupt line toward the microprocessor. The processor reads the interrupt bits to find the source endpoint and then empties that endpoint's buffer. Isochronous endpoints never receive a handshake, and their status is updated as soon as the packet ends. Other endpoints are updated after the ACK has gone out.

Top module: `usb_out_responder`

## Requirements
- R1: An OUT token whose address differs from `dev_addr`, whose endpoint number is not below N_EP, or whose endpoint has `ep_enable` low is ignored. Its data packet produces no FIFO write and no handshake, and leaves `ep_full` and `irq_flags` unchanged.
- R2: For an accepted token on an endpoint whose full flag is clear, each data byte presented with `rx_valid` appears one cycle later as a `fifo_we` pulse. The pulse carries the same byte on `fifo_data` and the endpoint number on `fifo_ep`.
- R3: For an accepted non-isochronous endpoint that stored the packet, `hs_valid` pulses with `hs_code` = 2'b01 (ACK) in the cycle after the cycle in which `rx_eop` is high.
- R4: For an accepted non-isochronous endpoint whose full flag is set, no FIFO write occurs. `hs_valid` pulses with `hs_code` = 2'b10 (NAK) in the cycle after `rx_eop`. `ep_full` and `irq_flags` stay unchanged.
- R5: An isochronous endpoint (`ep_iso` bit high at token time) never produces `hs_valid`, whether its buffer is empty or full.
- R6: After a stored non-isochronous packet, the endpoint's `ep_full` and `irq_flags` bits become 1 two cycles after `rx_eop`, one cycle after the ACK.
- R7: After a stored isochronous packet, the endpoint's `ep_full` and `irq_flags` bits become 1 in the cycle right after `rx_eop`.
- R8: `irq` is high exactly while any `irq_flags` bit is set. A one-cycle `irq_rd` pulse clears every set bit in the next cycle. A bit being set in the same cycle as the read stays set.
- R9: A pulse on `buf_clr[i]` clears `ep_full[i]` in the next cycle, after which an OUT to that endpoint is stored again.
- R10: After reset, `ep_full`, `irq_flags`, `irq`, `fifo_we` and `hs_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dev_addr | input | 7 | Assigned device address |
| tok_valid | input | 1 | One-cycle strobe: OUT token decoded |
| tok_addr | input | 7 | Address field of the token |
| tok_ep | input | 4 | Endpoint field of the token |
| rx_valid | input | 1 | Data byte valid |
| rx_data | input | 8 | Data byte |
| rx_eop | input | 1 | End of the data packet (may coincide with the last byte) |
| ep_enable | input | N_EP | Per-endpoint enable |
| ep_iso | input | N_EP | Per-endpoint isochronous type |
| buf_clr | input | N_EP | Processor strobe that empties an endpoint buffer |
| irq_rd | input | 1 | Processor read of the interrupt bits (clears them) |
| fifo_we | output | 1 | Store strobe toward the endpoint FIFO |
| fifo_ep | output | EP_W | Endpoint that receives the byte |
| fifo_data | output | 8 | Byte to store |
| hs_valid | output | 1 | Handshake to send |
| hs_code | output | 2 | 01 ACK, 10 NAK |
| ep_full | output | N_EP | Per-endpoint buffer-full status |
| irq_flags | output | N_EP | Pending interrupt bits |
| irq | output | 1 | Interrupt line to the processor |

## Verification
Some rules are checked by the embedded assertions on every cycle:
- a handshake only follows an end of packet;
- a discarding or ignored transaction never writes the FIFO;
- no ACK is given for an isochronous endpoint;
- a full or interrupt bit only rises in response to a completed store;
- a clear or a read empties its bit unless a store hits it at the same moment.

Other behaviours need the bench's scenarios, because they depend on the exact data and cycle counts:
- the exact bytes and their order;
- the one-cycle versus two-cycle status update for isochronous and ordinary endpoints;
- the read racing with a new interrupt;
- the acceptance of new data after a buffer clear.

// File: rtl/usb_out_pkg.sv
package usb_out_pkg;

    typedef enum logic [1:0] {
        HS_NONE = 2'b00,
        HS_ACK  = 2'b01,
        HS_NAK  = 2'b10
    } hs_code_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STORE,
        ST_DROP,
        ST_SKIP,
        ST_HS
    } txn_st_e;

endpackage

// File: rtl/usb_out_txn_fsm.sv
module usb_out_txn_fsm
    import usb_out_pkg::*;
#(
    parameter int N_EP    = 4,
    parameter int ADDR_W  = 7,
    parameter int EPNUM_W = 4,
    parameter int DATA_W  = 8,
    localparam int EP_W   = (N_EP > 1) ? $clog2(N_EP) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  dev_addr,
    input  logic               tok_valid,
    input  logic [ADDR_W-1:0]  tok_addr,
    input  logic [EPNUM_W-1:0] tok_ep,
    input  logic               rx_valid,
    input  logic [DATA_W-1:0]  rx_data,
    input  logic               rx_eop,
    input  logic [N_EP-1:0]    ep_enable,
    input  logic [N_EP-1:0]    ep_iso,
    input  logic [N_EP-1:0]    ep_full,
    output logic               fifo_we,
    output logic [EP_W-1:0]    fifo_ep,
    output logic [DATA_W-1:0]  fifo_data,
    output logic               hs_valid,
    output hs_code_e           hs_code,
    output logic               set_stb,
    output logic [EP_W-1:0]    set_ep
);

    typedef struct packed {
        txn_st_e           st;
        logic [EP_W-1:0]   ep;
        logic              iso;
        logic              we;
        logic [DATA_W-1:0] data;
        logic              hs_v;
        hs_code_e          hs;
    } fsm_s;

    fsm_s fsm_d, fsm_q;

    logic [EP_W-1:0] ep_idx;
    logic            ep_in_range;
    logic            tok_ok;

    always_comb begin
        ep_idx      = tok_ep[EP_W-1:0];
        ep_in_range = ({1'b0, tok_ep} < (EPNUM_W+1)'(N_EP));
        tok_ok      = (tok_addr == dev_addr) && ep_in_range && ep_enable[ep_idx];

        fsm_d      = fsm_q;
        fsm_d.we   = 1'b0;
        fsm_d.hs_v = 1'b0;
        fsm_d.hs   = HS_NONE;
        set_stb    = 1'b0;

        case (fsm_q.st)
            ST_IDLE: begin
                if (tok_valid) begin
                    fsm_d.ep  = ep_idx;
                    fsm_d.iso = ep_iso[ep_idx];
                    if (!tok_ok)
                        fsm_d.st = ST_SKIP;
                    else if (ep_full[ep_idx])
                        fsm_d.st = ST_DROP;
                    else
                        fsm_d.st = ST_STORE;
                end
            end
            ST_STORE: begin
                if (rx_valid) begin
                    fsm_d.we   = 1'b1;
                    fsm_d.data = rx_data;
                end
                if (rx_eop) begin
                    if (fsm_q.iso) begin
                        set_stb  = 1'b1;
                        fsm_d.st = ST_IDLE;
                    end else begin
                        fsm_d.hs_v = 1'b1;
                        fsm_d.hs   = HS_ACK;
                        fsm_d.st   = ST_HS;
                    end
                end
            end
            ST_DROP: begin
                if (rx_eop) begin
                    fsm_d.hs_v = !fsm_q.iso;
                    fsm_d.hs   = fsm_q.iso ? HS_NONE : HS_NAK;
                    fsm_d.st   = ST_IDLE;
                end
            end
            ST_SKIP: begin
                if (rx_eop)
                    fsm_d.st = ST_IDLE;
            end
            ST_HS: begin
                set_stb  = 1'b1;
                fsm_d.st = ST_IDLE;
            end
            default: fsm_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{st: ST_IDLE, ep: '0, iso: 1'b0, we: 1'b0,
                       data: '0, hs_v: 1'b0, hs: HS_NONE};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign fifo_we   = fsm_q.we;
    assign fifo_ep   = fsm_q.ep;
    assign fifo_data = fsm_q.data;
    assign hs_valid  = fsm_q.hs_v;
    assign hs_code   = fsm_q.hs;
    assign set_ep    = fsm_q.ep;

    AST_HS_AFTER_EOP: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid |-> $past(rx_eop)); // R3
    AST_ISO_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid |-> !$past(fsm_q.iso)); // R5
    AST_DROP_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_DROP) |=> !fifo_we); // R4
    AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_SKIP) |=> (!fifo_we && !hs_valid)); // R1

endmodule

// File: rtl/usb_out_ep_state.sv
module usb_out_ep_state #(
    parameter int N_EP  = 4,
    localparam int EP_W = (N_EP > 1) ? $clog2(N_EP) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_stb,
    input  logic [EP_W-1:0] set_ep,
    input  logic [N_EP-1:0] buf_clr,
    input  logic            irq_rd,
    output logic [N_EP-1:0] ep_full,
    output logic [N_EP-1:0] irq_flags
);

    typedef struct packed {
        logic full;
        logic pend;
    } ep_s;

    for (genvar gi = 0; gi < N_EP; gi++) begin : g_ep
        ep_s  ep_d, ep_q;
        logic hit;

        always_comb begin
            hit  = set_stb && (set_ep == EP_W'(gi));
            ep_d = ep_q;
            if (buf_clr[gi])
                ep_d.full = 1'b0;
            if (irq_rd)
                ep_d.pend = 1'b0;
            if (hit) begin
                ep_d.full = 1'b1;
                ep_d.pend = 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ep_q <= '{full: 1'b0, pend: 1'b0};
            else
                ep_q <= ep_d;
        end

        assign ep_full[gi]   = ep_q.full;
        assign irq_flags[gi] = ep_q.pend;

        AST_FULL_FROM_STORE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ep_full[gi]) |-> $past(set_stb && (set_ep == EP_W'(gi)))); // R6
        AST_IRQ_FROM_STORE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_flags[gi]) |-> $past(set_stb && (set_ep == EP_W'(gi)))); // R7
        AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
            (buf_clr[gi] && !(set_stb && (set_ep == EP_W'(gi)))) |=> !ep_full[gi]); // R9
        AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_rd && !(set_stb && (set_ep == EP_W'(gi)))) |=> !irq_flags[gi]); // R8
    end

endmodule

// File: rtl/usb_out_responder.sv
module usb_out_responder
    import usb_out_pkg::*;
#(
    parameter int N_EP    = 4,
    parameter int ADDR_W  = 7,
    parameter int EPNUM_W = 4,
    parameter int DATA_W  = 8,
    localparam int EP_W   = (N_EP > 1) ? $clog2(N_EP) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  dev_addr,
    input  logic               tok_valid,
    input  logic [ADDR_W-1:0]  tok_addr,
    input  logic [EPNUM_W-1:0] tok_ep,
    input  logic               rx_valid,
    input  logic [DATA_W-1:0]  rx_data,
    input  logic               rx_eop,
    input  logic [N_EP-1:0]    ep_enable,
    input  logic [N_EP-1:0]    ep_iso,
    input  logic [N_EP-1:0]    buf_clr,
    input  logic               irq_rd,
    output logic               fifo_we,
    output logic [EP_W-1:0]    fifo_ep,
    output logic [DATA_W-1:0]  fifo_data,
    output logic               hs_valid,
    output logic [1:0]         hs_code,
    output logic [N_EP-1:0]    ep_full,
    output logic [N_EP-1:0]    irq_flags,
    output logic               irq
);

    logic            set_stb;
    logic [EP_W-1:0] set_ep;
    hs_code_e        hs_code_w;

    usb_out_txn_fsm #(
        .N_EP(N_EP), .ADDR_W(ADDR_W), .EPNUM_W(EPNUM_W), .DATA_W(DATA_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .dev_addr  (dev_addr),
        .tok_valid (tok_valid),
        .tok_addr  (tok_addr),
        .tok_ep    (tok_ep),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_eop    (rx_eop),
        .ep_enable (ep_enable),
        .ep_iso    (ep_iso),
        .ep_full   (ep_full),
        .fifo_we   (fifo_we),
        .fifo_ep   (fifo_ep),
        .fifo_data (fifo_data),
        .hs_valid  (hs_valid),
        .hs_code   (hs_code_w),
        .set_stb   (set_stb),
        .set_ep    (set_ep)
    );

    usb_out_ep_state #(.N_EP(N_EP)) u_ep_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_stb   (set_stb),
        .set_ep    (set_ep),
        .buf_clr   (buf_clr),
        .irq_rd    (irq_rd),
        .ep_full   (ep_full),
        .irq_flags (irq_flags)
    );

    assign hs_code = hs_code_w;
    assign irq     = |irq_flags;

    AST_IRQ_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(irq_rd)); // R8
    AST_HS_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid |-> ($countones(hs_code) == 1)); // R3

endmodule

// File: tb/usb_out_responder_tb.sv
`timescale 1ns/1ps
module usb_out_responder_tb;

    localparam int N_EP = 4;
    localparam logic [6:0] DEV = 7'h15;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] dev_addr = DEV;
    logic       tok_valid = 1'b0;
    logic [6:0] tok_addr = '0;
    logic [3:0] tok_ep = '0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_eop = 1'b0;
    logic [N_EP-1:0] ep_enable = 4'b0111;
    logic [N_EP-1:0] ep_iso    = 4'b0100;
    logic [N_EP-1:0] buf_clr   = '0;
    logic       irq_rd = 1'b0;
    logic       fifo_we;
    logic [1:0] fifo_ep;
    logic [7:0] fifo_data;
    logic       hs_valid;
    logic [1:0] hs_code;
    logic [N_EP-1:0] ep_full;
    logic [N_EP-1:0] irq_flags;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [9:0] wr_q[$];
    logic [1:0] hs_q[$];

    always #2.5 clk = ~clk;

    usb_out_responder #(.N_EP(N_EP)) u_dut (
        .clk(clk), .rst_n(rst_n), .dev_addr(dev_addr),
        .tok_valid(tok_valid), .tok_addr(tok_addr), .tok_ep(tok_ep),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_eop(rx_eop),
        .ep_enable(ep_enable), .ep_iso(ep_iso), .buf_clr(buf_clr),
        .irq_rd(irq_rd), .fifo_we(fifo_we), .fifo_ep(fifo_ep),
        .fifo_data(fifo_data), .hs_valid(hs_valid), .hs_code(hs_code),
        .ep_full(ep_full), .irq_flags(irq_flags), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // kind: 0 ignored, 1 stored non-iso, 2 stored iso, 3 full non-iso, 4 full iso
    task automatic out_txn(input logic [6:0] addr, input logic [3:0] ep, input int nbytes,
                           input logic [7:0] seed, input int kind, input bit rd_at_eop);
        if (kind == 1 || kind == 2)
            for (int i = 0; i < nbytes; i++) wr_q.push_back({ep[1:0], 8'(seed + i)});
        if (kind == 1) hs_q.push_back(2'b01);
        if (kind == 3) hs_q.push_back(2'b10);
        @(posedge clk); #1;
        tok_valid = 1'b1; tok_addr = addr; tok_ep = ep;
        @(posedge clk); #1;
        tok_valid = 1'b0;
        for (int i = 0; i < nbytes; i++) begin
            rx_valid = 1'b1;
            rx_data  = 8'(seed + i);
            rx_eop   = (i == nbytes - 1);
            irq_rd   = rd_at_eop && (i == nbytes - 1);
            @(posedge clk); #1;
        end
        rx_valid = 1'b0; rx_eop = 1'b0; irq_rd = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Monitor: pops expected FIFO writes (R2) and handshakes (R3, R4, R5)
    always @(negedge clk) begin
        if (rst_n) begin
            if (fifo_we) begin
                if (wr_q.size() == 0)
                    chk(1'b0, "R2 unexpected write", {fifo_ep, fifo_data}, 0);
                else begin
                    logic [9:0] e;
                    e = wr_q.pop_front();
                    chk({fifo_ep, fifo_data} == e, "R2 write", {fifo_ep, fifo_data}, e);
                end
            end
            if (hs_valid) begin
                if (hs_q.size() == 0)
                    chk(1'b0, "R5/R1 unexpected handshake", hs_code, 0);
                else begin
                    logic [1:0] h;
                    h = hs_q.pop_front();
                    chk(hs_code == h, "R3/R4 handshake", hs_code, h);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(ep_full == 0, "R10 ep_full", ep_full, 0);
        chk(irq_flags == 0, "R10 irq_flags", irq_flags, 0);
        chk(irq == 0, "R10 irq", irq, 0);
        chk(fifo_we == 0 && hs_valid == 0, "R10 outputs", {fifo_we, hs_valid}, 0);

        // R2 R3 R6: stored non-iso packet on ep1
        out_txn(DEV, 4'd1, 4, 8'h30, 1, 1'b0);
        @(negedge clk);
        chk(ep_full[1] == 0, "R6 full not yet", ep_full[1], 0);
        @(negedge clk);
        chk(ep_full[1] == 1, "R6 full set", ep_full[1], 1);
        chk(irq_flags == 4'b0010, "R6 irq bit", irq_flags, 4'b0010);
        chk(irq == 1, "R8 irq line", irq, 1);

        // R4: ep1 full -> NAK, nothing stored, status unchanged
        out_txn(DEV, 4'd1, 3, 8'h50, 3, 1'b0);
        repeat (3) @(negedge clk);
        chk(ep_full == 4'b0010, "R4 full unchanged", ep_full, 4'b0010);
        chk(irq_flags == 4'b0010, "R4 irq unchanged", irq_flags, 4'b0010);

        // R1: wrong address, out-of-range endpoint, disabled endpoint
        out_txn(7'h16, 4'd0, 2, 8'h60, 0, 1'b0);
        out_txn(DEV, 4'd5, 2, 8'h64, 0, 1'b0);
        out_txn(DEV, 4'd3, 2, 8'h68, 0, 1'b0);
        repeat (3) @(negedge clk);
        chk(ep_full == 4'b0010, "R1 full unchanged", ep_full, 4'b0010);
        chk(irq_flags == 4'b0010, "R1 irq unchanged", irq_flags, 4'b0010);

        // R7 R8: iso ep2 store with processor read in the eop cycle
        out_txn(DEV, 4'd2, 5, 8'hA0, 2, 1'b1);
        @(negedge clk);
        chk(ep_full[2] == 1, "R7 iso full next cycle", ep_full[2], 1);
        chk(irq_flags == 4'b0100, "R8 read vs set", irq_flags, 4'b0100);
        chk(irq == 1, "R8 irq still high", irq, 1);

        // R5: iso ep2 while full -> no handshake, no write
        out_txn(DEV, 4'd2, 2, 8'hB0, 4, 1'b0);
        repeat (3) @(negedge clk);
        chk(ep_full[2] == 1, "R5 iso full stays", ep_full[2], 1);

        // R8: plain read clears all
        @(posedge clk); #1 irq_rd = 1'b1;
        @(posedge clk); #1 irq_rd = 1'b0;
        @(negedge clk);
        chk(irq_flags == 0, "R8 read clears", irq_flags, 0);
        chk(irq == 0, "R8 irq low", irq, 0);

        // R9: clear ep1 buffer then store again
        @(posedge clk); #1 buf_clr = 4'b0010;
        @(posedge clk); #1 buf_clr = 4'b0000;
        @(negedge clk);
        chk(ep_full == 4'b0100, "R9 clear", ep_full, 4'b0100);
        out_txn(DEV, 4'd1, 1, 8'hC7, 1, 1'b0);
        repeat (2) @(negedge clk);
        chk(ep_full[1] == 1, "R9 stored after clear", ep_full[1], 1);

        repeat (4) @(negedge clk);
        chk(wr_q.size() == 0, "R2 all writes seen", wr_q.size(), 0);
        chk(hs_q.size() == 0, "R3 all handshakes seen", hs_q.size(), 0);
        finish_run();
    end

endmodule